// File: doc/BRIEF.md
# Fractional Signed-by-Unsigned Multiply Unit

This execution unit sits beside the register file of an 8-bit processor core. It looks at every issued 16-bit instruction word, recognises one opcode (a fractional multiply), and selects two operands from an eight-register window. The window covers registers 16 to 23. The first operand is read as a two's-complement number and the second as an unsigned number. The unit forms their 16-bit product and shifts it left by one place, which turns the product into 1.15 fixed-point form. It then presents the value for a write to the fixed register pair 1:0, together with new zero and carry flags.

All outputs are registered, so a result appears one clock after the instruction is issued. The core's writeback stage uses `wr_en` to store `result` into registers 0 and 1 and to update the Z and C bits of its status register. When a word is not this opcode, the unit raises no write, and its outputs keep their last values.

Top module: `fmsu_unit`

## Requirements
- R1: A word is recognised when `instr[15:7]` equals 9'b0000_0011_1 and `instr[3]` is 1, and `instr_valid` is high. The cycle after such a word, `wr_en` is 1.
- R2: `instr[6:4]` selects the first operand and `instr[2:0]` selects the second. A field value n selects register 16+n, which is the byte at `reg_window[8n+7:8n]`.
- R3: The first operand is interpreted as signed (−128..127) and the second as unsigned (0..255). The product is their exact 16-bit two's-complement product.
- R4: `result` equals the product shifted left by one bit, so `result[0]` is 0 after every write. `result[7:0]` is the byte for register 0 and `result[15:8]` is the byte for register 1.
- R5: On a write, `z_flag` is 1 exactly when the 16-bit `result` is zero.
- R6: On a write, `c_flag` equals bit 15 of the product before the shift.
- R7: A word that does not match, or any cycle with `instr_valid` low, gives `wr_en` = 0 on the next cycle and leaves `result`, `z_flag` and `c_flag` unchanged.
- R8: While `rst` is high and after it, until a match is seen, `wr_en`, `result`, `z_flag` and `c_flag` are all 0.
- R9: Matching words issued on consecutive cycles each produce their own result, one cycle after issue, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | The instruction word is issued this cycle |
| instr | input | 16 | Instruction word |
| reg_window | input | 64 | Registers 16..23, register 16+n in byte n |
| wr_en | output | 1 | Write the pair 1:0 and flags Z and C |
| result | output | 16 | Value for the register pair, low byte to register 0 |
| z_flag | output | 1 | Zero flag |
| c_flag | output | 1 | Carry flag |

## Verification
The hardest condition to reach from the ports is a mismatching word arriving directly after a match. In that case the held outputs must differ from reset values, or a hold cannot be told apart from a clear. The bench therefore interleaves near-miss words with matches: words that differ from the pattern only in bit 3, or only in bit 7, or that match while `instr_valid` is low. Each of these follows a match that left a nonzero result and a set carry. The extreme operands −128×255, −128×1 and 0×x are driven to cover carry set together with a small result, and zero.

// File: rtl/fmsu_pkg.sv
package fmsu_pkg;

    localparam int DATA_W   = 8;
    localparam int PROD_W   = 2 * DATA_W;
    localparam int WIN_N    = 8;
    localparam int IDX_W    = $clog2(WIN_N);
    localparam int INSTR_W  = 16;
    localparam int WIN_W    = WIN_N * DATA_W;

    // fixed opcode bits: instr[15:7] and instr[3]
    localparam logic [8:0] OPC_HI = 9'b0000_0011_1;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] sel_s;
        logic [IDX_W-1:0] sel_u;
    } dec_t;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              zero;
        logic              carry;
    } res_t;

    function automatic dec_t decode(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.hit   = (w[15:7] == OPC_HI) && w[3];
        d.sel_s = w[6:4];
        d.sel_u = w[2:0];
        return d;
    endfunction

    function automatic logic [PROD_W-1:0] smul_su(input logic [DATA_W-1:0] s,
                                                  input logic [DATA_W-1:0] u);
        logic signed [PROD_W:0] full;
        full = $signed({{(PROD_W-DATA_W+1){s[DATA_W-1]}}, s})
             * $signed({{(PROD_W-DATA_W+1){1'b0}}, u});
        return full[PROD_W-1:0];
    endfunction

endpackage

// File: rtl/fmsu_decode.sv
module fmsu_decode
    import fmsu_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);
    dec_t raw;

    always_comb begin
        raw     = decode(word);
        dec     = raw;
        dec.hit = raw.hit && valid;
    end
endmodule

// File: rtl/fmsu_opsel.sv
module fmsu_opsel
    import fmsu_pkg::*;
(
    input  logic [WIN_W-1:0]  window,
    input  logic [IDX_W-1:0]  sel_s,
    input  logic [IDX_W-1:0]  sel_u,
    output logic [DATA_W-1:0] op_s,
    output logic [DATA_W-1:0] op_u
);
    logic [DATA_W-1:0] slot [WIN_N];

    for (genvar g = 0; g < WIN_N; g++) begin : g_slot
        assign slot[g] = window[g*DATA_W +: DATA_W];
    end

    always_comb begin
        op_s = slot[sel_s];
        op_u = slot[sel_u];
    end
endmodule

// File: rtl/fmsu_core.sv
module fmsu_core
    import fmsu_pkg::*;
(
    input  logic [DATA_W-1:0] op_s,
    input  logic [DATA_W-1:0] op_u,
    output res_t              res
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod      = smul_su(op_s, op_u);
        res.value = {prod[PROD_W-2:0], 1'b0};
        res.carry = prod[PROD_W-1];
        res.zero  = ({prod[PROD_W-2:0], 1'b0} == '0);
    end
endmodule

// File: rtl/fmsu_unit.sv
module fmsu_unit
    import fmsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [15:0] instr,
    input  logic [63:0] reg_window,
    output logic        wr_en,
    output logic [15:0] result,
    output logic        z_flag,
    output logic        c_flag
);
    dec_t              dec;
    logic [DATA_W-1:0] op_s;
    logic [DATA_W-1:0] op_u;
    res_t              nxt;
    res_t              held;
    logic              we_q;

    fmsu_decode u_dec (
        .valid (instr_valid),
        .word  (instr),
        .dec   (dec)
    );

    fmsu_opsel u_sel (
        .window (reg_window),
        .sel_s  (dec.sel_s),
        .sel_u  (dec.sel_u),
        .op_s   (op_s),
        .op_u   (op_u)
    );

    fmsu_core u_core (
        .op_s (op_s),
        .op_u (op_u),
        .res  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b0;
            held <= '0;
        end else begin
            we_q <= dec.hit;
            if (dec.hit) begin
                held <= nxt;
            end
        end
    end

    assign wr_en  = we_q;
    assign result = held.value;
    assign z_flag = held.zero;
    assign c_flag = held.carry;
endmodule

// File: rtl/fmsu_checker.sv
module fmsu_checker (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [15:0] instr,
    input logic        wr_en,
    input logic [15:0] result,
    input logic        z_flag,
    input logic        c_flag
);
    logic seen;
    logic issue_hit;

    assign issue_hit = instr_valid && (instr[15:7] == 9'b0000_0011_1) && instr[3];

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r1_write_follows_match: assert property (@(posedge clk) disable iff (rst)
        issue_hit |=> wr_en);

    a_r4_lsb_clear: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (result[0] == 1'b0));

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (z_flag == (result == 16'h0)));

    a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
        (seen && !issue_hit) |=> !wr_en);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (seen && !issue_hit) |=> ($stable(result) && $stable(z_flag) && $stable(c_flag)));

    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (!wr_en && result == 16'h0 && !z_flag && !c_flag));
endmodule

bind fmsu_unit fmsu_checker u_fmsu_checker (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .wr_en       (wr_en),
    .result      (result),
    .z_flag      (z_flag),
    .c_flag      (c_flag)
);

// File: tb/test_fmsu_unit.sv
module test_fmsu_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0;
    logic [63:0] reg_window = 64'h0;
    logic        wr_en;
    logic [15:0] result;
    logic        z_flag;
    logic        c_flag;

    int n_vec  = 0;
    int n_fail = 0;

    typedef struct {
        logic        we;
        logic [15:0] res;
        logic        z;
        logic        c;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] m_res = 16'h0;
    logic        m_z = 1'b0;
    logic        m_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmsu_unit i_fmsu_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr),
        .reg_window  (reg_window),
        .wr_en       (wr_en),
        .result      (result),
        .z_flag      (z_flag),
        .c_flag      (c_flag)
    );

    function automatic logic [15:0] opword(input int d, input int r);
        return {9'b0000_0011_1, d[2:0], 1'b1, r[2:0]};
    endfunction

    task automatic issue(input logic v, input logic [15:0] w, input logic [63:0] win,
                         input string tag);
        exp_t e;
        int   sv, uv, p;
        logic hit;
        @(negedge clk);
        #1;
        instr_valid = v;
        instr       = w;
        reg_window  = win;
        hit = v && (w[15:7] == 9'b0000_0011_1) && w[3];
        if (hit) begin
            sv = $signed(win[w[6:4]*8 +: 8]);
            uv = int'(win[w[2:0]*8 +: 8]);
            p  = sv * uv;
            m_res = {p[14:0], 1'b0};
            m_c   = p[15];
            m_z   = (m_res == 16'h0);
        end
        e.we = hit; e.res = m_res; e.z = m_z; e.c = m_c; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_one(input exp_t e);
        n_vec++;
        if (wr_en !== e.we || result !== e.res || z_flag !== e.z || c_flag !== e.c) begin
            n_fail++;
            $display("FAIL %s: got we=%b res=%h z=%b c=%b, expected we=%b res=%h z=%b c=%b",
                     e.tag, wr_en, result, z_flag, c_flag, e.we, e.res, e.z, e.c);
        end
    endtask

    // monitor: one expected item per cycle, checked at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) check_one(q.pop_front());
        end
    end

    function automatic logic [63:0] win_of(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3,
                                          input logic [7:0] b4, input logic [7:0] b5,
                                          input logic [7:0] b6, input logic [7:0] b7);
        return {b7, b6, b5, b4, b3, b2, b1, b0};
    endfunction

    initial begin
        logic [63:0] w1;
        logic [63:0] w2;
        exp_t        er;
        w1 = win_of(8'h80, 8'hFF, 8'h01, 8'h7F, 8'h00, 8'hC3, 8'h05, 8'h40);
        w2 = win_of(8'hFE, 8'h10, 8'h80, 8'h02, 8'h3A, 8'hA5, 8'h7F, 8'h81);

        repeat (3) @(negedge clk);
        // R8: outputs idle during reset
        er.we = 0; er.res = 16'h0; er.z = 0; er.c = 0; er.tag = "R8 reset";
        check_one(er);
        @(negedge clk);
        rst = 1'b0;
        check_one(er);

        // R3 R6: -128 * 255, carry set
        issue(1, opword(0, 1), w1, "R3 R6 min x max");
        // R7: bit 3 cleared, near miss, holds nonzero result
        issue(1, opword(0, 1) & ~16'h0008, w1, "R7 bit3 miss");
        // R7: valid low with matching word
        issue(0, opword(3, 3), w1, "R7 valid low");
        // R7: bit 7 cleared
        issue(1, opword(3, 3) & ~16'h0080, w1, "R7 bit7 miss");
        // R3 R6: -128 * 1
        issue(1, opword(0, 2), w1, "R3 R6 min x one");
        // R5: zero operand
        issue(1, opword(4, 1), w1, "R5 zero");
        issue(1, 16'h0000, w1, "R7 zero word hold");
        // R4: positive x unsigned high, shift
        issue(1, opword(2, 0), w1, "R4 one x 128");
        // R2 R9: back-to-back, all index pairs over two windows
        for (int d = 0; d < 8; d++) begin
            for (int r = 0; r < 8; r++) begin
                issue(1, opword(d, r), (d[0] ? w2 : w1), "R2 R9 sweep");
            end
        end
        // R7: other opcodes
        issue(1, 16'h0388, w2, "R1 match base");
        issue(1, 16'h0208, w2, "R7 other op");
        issue(1, 16'hFFFF, w2, "R7 all ones");
        // R1: random-ish windows and words
        for (int k = 0; k < 200; k++) begin
            logic [63:0] wr;
            logic [15:0] iw;
            wr = {$urandom, $urandom};
            iw = (k % 3 == 0) ? 16'($urandom) : opword(k % 8, (k * 5) % 8);
            issue(k % 7 != 0, iw, wr, "R1 R3 mixed");
        end
        @(negedge clk);
        instr_valid = 0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d results never checked, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule